// File: doc/BRIEF.md
# ALU with flags and condition evaluator

This block is the integer execute unit of a small in-order processor. It adds, subtracts, ANDs or XORs two 32-bit operands under a 2-bit function code and registers the result. Subtraction takes the first operand from the second. The same result also drives three condition flags: zero, sign and signed overflow. The flags are written into a flag register only when a write enable is raised. An integer-operation instruction raises it. Address and stack-pointer arithmetic that reuse the adder leave it low, so the flags they would produce are discarded.

A condition evaluator turns a 3-bit condition code and the stored flags into a single taken/move bit. Conditional branches and conditional moves use this bit alike. Code 0 is unconditional, which makes a plain register move a conditional move that always fires. Integers are treated as signed, so there is no carry flag. Operands are chosen outside the block.

Top module: `alu_cc_unit`

## Requirements
- R1: With op_fn = 0 (add), val_e equals opnd_b + opnd_a modulo 2^32 on the clock edge after the operands are applied.
- R2: With op_fn = 1 (subtract), val_e equals opnd_b - opnd_a modulo 2^32, one clock later.
- R3: op_fn = 2 gives the bitwise AND and op_fn = 3 gives the bitwise XOR of the operands, one clock later.
- R4: When flag_we is high at an edge, zf becomes 1 exactly when the new result is zero, and sf becomes bit 31 of the new result.
- R5: When flag_we is high, of becomes 1 exactly when the signed add or subtract result falls outside the signed 32-bit range. For AND and XOR it becomes 0.
- R6: When flag_we is low at an edge, zf, sf and of keep their values, whatever operation is performed.
- R7: Synchronous active-high reset sets val_e = 0, zf = 1, sf = 0, of = 0 and cnd = 0.
- R8: cnd is registered. It is the condition selected by cond_fn, evaluated on the flag values held before that edge. The encodings are: 0 always, 1 signed less-or-equal ((sf^of)|zf), 2 signed less (sf^of), 3 equal (zf), 4 not-equal (!zf), 5 signed greater-or-equal (!(sf^of)), 6 signed greater (!(sf^of) & !zf).
- R9: The undefined condition code 7 yields cnd = 0 whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_fn | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_a | input | 32 | Operand A (subtrahend for subtract) |
| opnd_b | input | 32 | Operand B (minuend for subtract) |
| flag_we | input | 1 | Write the flags computed from this operation |
| cond_fn | input | 3 | Condition code for branch or move |
| val_e | output | 32 | Registered result |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored sign flag |
| of | output | 1 | Stored signed-overflow flag |
| cnd | output | 1 | Registered condition outcome |

## Verification
Each result is due one clock after its stimulus:
- val_e and the flags reflect the operands, op_fn and flag_we present at the previous edge.
- cnd reflects the cond_fn of the previous edge, combined with the flags as they stood before that edge.

A flag write and a condition test issued in the same cycle therefore sees the old flags. A test issued in the following cycle sees the new ones.

The bench drives inputs on the falling edge and samples one time unit after each rising edge. Its reference model computes cnd from its flag copy before applying that cycle's flag update, which reproduces this ordering. Every output is compared on every cycle, including the cycles in which flag_we is low.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int FN_W   = 2;
  localparam int COND_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 3'd0,
    CC_LE     = 3'd1,
    CC_LT     = 3'd2,
    CC_EQ     = 3'd3,
    CC_NE     = 3'd4,
    CC_GE     = 3'd5,
    CC_GT     = 3'd6,
    CC_RSVD   = 3'd7
  } cc_code_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output flags_t            nxt_flags
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] dif;
  logic              ovf;

  assign sum = b + a;
  assign dif = b - a;

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (fn)
      FN_ADD: begin
        res = sum;
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
      end
      FN_SUB: begin
        res = dif;
        ovf = (a[MSB] != b[MSB]) && (dif[MSB] != b[MSB]);
      end
      FN_AND: res = b & a;
      FN_XOR: res = b ^ a;
      default: res = '0;
    endcase
  end

  assign nxt_flags.zf = (res == '0);
  assign nxt_flags.sf = res[MSB];
  assign nxt_flags.of = ovf;
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= FLAGS_RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  cc_code_e code,
  input  flags_t   fl,
  output logic     take
);
  logic lt;
  assign lt = fl.sf ^ fl.of;

  always_comb begin
    case (code)
      CC_ALWAYS: take = 1'b1;
      CC_LE:     take = lt | fl.zf;
      CC_LT:     take = lt;
      CC_EQ:     take = fl.zf;
      CC_NE:     take = ~fl.zf;
      CC_GE:     take = ~lt;
      CC_GT:     take = ~lt & ~fl.zf;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_fn,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              flag_we,
  input  logic [2:0]        cond_fn,
  output logic [DATA_W-1:0] val_e,
  output logic              zf,
  output logic              sf,
  output logic              of,
  output logic              cnd
);
  logic [DATA_W-1:0] res_c;
  flags_t            nxt_flags;
  flags_t            flags_q;
  logic              take_c;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .fn        (alu_fn_e'(op_fn)),
    .a         (opnd_a),
    .b         (opnd_b),
    .res       (res_c),
    .nxt_flags (nxt_flags)
  );

  flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .we  (flag_we),
    .d   (nxt_flags),
    .q   (flags_q)
  );

  cond_eval u_cond (
    .code (cc_code_e'(cond_fn)),
    .fl   (flags_q),
    .take (take_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      val_e <= '0;
      cnd   <= 1'b0;
    end else begin
      val_e <= res_c;
      cnd   <= take_c;
    end
  end

  assign zf = flags_q.zf;
  assign sf = flags_q.sf;
  assign of = flags_q.of;
endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_fn,
  input logic              flag_we,
  input logic [2:0]        cond_fn,
  input logic [DATA_W-1:0] val_e,
  input logic              zf,
  input logic              sf,
  input logic              of,
  input logic              cnd
);
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flag_we)) |-> $stable({zf, sf, of})); // R6
  AST_ZF_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_we)) |-> (zf == (val_e == '0))); // R4
  AST_SF_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_we)) |-> (sf == val_e[DATA_W-1])); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_we) && $past(op_fn[1])) |-> !of); // R5
  AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_fn) == 3'd0) |-> cnd); // R8
  AST_COND_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_fn) == 3'd7) |-> !cnd); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (val_e == '0 && zf && !sf && !of && !cnd)); // R7
endmodule

bind alu_cc_unit alu_cc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_fn   (op_fn),
  .flag_we (flag_we),
  .cond_fn (cond_fn),
  .val_e   (val_e),
  .zf      (zf),
  .sf      (sf),
  .of      (of),
  .cnd     (cnd)
);

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   op_fn;
  logic [W-1:0] opnd_a, opnd_b;
  logic         flag_we;
  logic [2:0]   cond_fn;
  logic [W-1:0] val_e;
  logic         zf, sf, of, cnd;

  int n_vec  = 0;
  int n_miss = 0;

  // model state
  logic m_z = 1'b1, m_s = 1'b0, m_o = 1'b0;

  always #2 clk = ~clk;

  alu_cc_unit #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .op_fn(op_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_we(flag_we), .cond_fn(cond_fn), .val_e(val_e),
    .zf(zf), .sf(sf), .of(of), .cnd(cnd)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic cond_ref(input int code, input logic z, input logic s, input logic o);
    logic less;
    less = (s != o);
    case (code)
      0: return 1'b1;
      1: return less || z;
      2: return less;
      3: return z;
      4: return !z;
      5: return !less;
      6: return !less && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input int fn, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic we, input int cc);
    longint sa, sb, wide;
    logic [W-1:0] r;
    logic ov, c_exp;
    string rt;
    @(negedge clk);
    op_fn = fn[1:0]; opnd_a = a; opnd_b = b; flag_we = we; cond_fn = cc[2:0];
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ov = 1'b0;
    case (fn)
      0: begin wide = sb + sa; r = b + a; rt = "R1"; end
      1: begin wide = sb - sa; r = b - a; rt = "R2"; end
      2: begin wide = 0; r = b & a; rt = "R3"; end
      default: begin wide = 0; r = b ^ a; rt = "R3"; end
    endcase
    if (fn < 2) ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    c_exp = cond_ref(cc, m_z, m_s, m_o);
    if (we) begin m_z = (r == 0); m_s = r[W-1]; m_o = ov; end
    @(posedge clk); #1;
    check(rt, val_e, r);
    check(we ? "R4 zf" : "R6 zf", zf, m_z);
    check(we ? "R4 sf" : "R6 sf", sf, m_s);
    check(we ? "R5 of" : "R6 of", of, m_o);
    check(cc == 7 ? "R9 cnd" : "R8 cnd", cnd, c_exp);
  endtask

  initial begin
    #400000;
    n_miss++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    rst = 1'b1; op_fn = 0; opnd_a = 0; opnd_b = 0; flag_we = 0; cond_fn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0.5;
    check("R7 val_e", val_e, 0);
    check("R7 zf", zf, 1);
    check("R7 sf", sf, 0);
    check("R7 of", of, 0);
    check("R7 cnd", cnd, 0);

    // R1 adds: plain, positive overflow, wrap to zero
    step(0, 32'd7, 32'd5, 1, 0);
    step(0, 32'd1, 32'h7FFF_FFFF, 1, 2);
    step(0, 32'd1, 32'hFFFF_FFFF, 1, 2);
    step(0, 32'h8000_0000, 32'h8000_0000, 1, 3);
    // R2 subtract: b - a, negative, negative overflow
    step(1, 32'd5, 32'd3, 1, 3);
    step(1, 32'd1, 32'h8000_0000, 1, 1);
    step(1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 6);
    step(1, 32'd9, 32'd9, 1, 5);
    // R3 logic ops clear overflow (R5)
    step(0, 32'd1, 32'h7FFF_FFFF, 1, 0);
    step(2, 32'hF0F0_F0F0, 32'h8F00_00FF, 1, 2);
    step(3, 32'h1234_5678, 32'h1234_5678, 1, 4);
    // R6 flag write disabled across every operation
    step(1, 32'd1, 32'h8000_0000, 1, 0);
    for (int k = 0; k < 4; k++) step(k, 32'h0, 32'h0, 0, 2);
    // R8, R9 sweep all codes over several flag states
    for (int st = 0; st < 4; st++) begin
      case (st)
        0: step(1, 32'd4, 32'd4, 1, 0);
        1: step(1, 32'd4, 32'd2, 1, 0);
        2: step(1, 32'd2, 32'd4, 1, 0);
        default: step(1, 32'd1, 32'h8000_0000, 1, 0);
      endcase
      for (int c = 0; c < 8; c++) step(2, 32'h0, 32'h0, 0, c);
    end
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 3)), $urandom, (i % 5 == 0) ? 32'h8000_0000 : $urandom,
           1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
    // synchronous reset mid-run (R7)
    step(1, 32'd5, 32'd3, 1, 0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R7 val_e", val_e, 0);
    check("R7 zf", zf, 1);
    check("R7 sf", sf, 0);
    check("R7 of", of, 0);
    check("R7 cnd", cnd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule